// File: doc/BRIEF.md
# Addressed Serial Control Register Interface

This block is a three-wire serial slave for the control and status registers of a frequency-synthesizer controller. A host frames each transfer with a framing line held high. It clocks in an 8-bit address and then 24 data bits on a serial data line, one bit per rising edge of the serial clock. Two addresses name writable control words. These drive the parallel control buses to the divider, reference, port and power blocks. Two other addresses name read-only status words: the 20-bit general counter result, and a port readback word that combines stored port bits with live input levels.

The serial lines are oversampled in the system clock domain. A write is committed to its register only when the framing line falls after exactly 32 serial clock edges, so a frame that is too short or too long leaves every register unchanged. On a read, the addressed status word is captured when the eighth address bit arrives. It is then shifted out MSB first, with the output enable asserted only for the 24 data bits.

Top module: `ssc_ctrl_if`

## Requirements
- R1: Within a frame (ser_frame high), ser_dat is sampled on each rising ser_clk edge, MSB first: the first 8 bits form the address and the next 24 the data word.
- R2: A write takes effect only on the falling edge of ser_frame, and only if exactly 32 rising ser_clk edges were seen in that frame; frames of 31 or 33 edges change nothing.
- R3: Address 0xD0 loads ctrl_main with the data word, and address 0xD2 loads ctrl_aux.
- R4: Frames to any address other than 0xD0 or 0xD2 leave both control words unchanged. This includes the read addresses 0xD1 and 0xD3 and unused addresses such as 0xD5.
- R5: After reset ctrl_main = 0x012345, ctrl_aux = 0x000C00, standby = 0 and ser_dout_oe = 0.
- R6: Bit 23 of ctrl_aux (the test bit) is always 0, whatever is written to it.
- R7: standby is 1 exactly when ctrl_main bits 23..21 are all 1.
- R8: A frame to 0xD1 returns {4'b0, cnt_result}. The word is captured at the 8th rising ser_clk edge. Bit 23 is on ser_dout after that edge, and each later rising edge moves to the next lower bit, through edge 31.
- R9: A frame to 0xD3 returns a word with bits 4..0 = gpio_in, bits 9..5 = ctrl_aux bits 4..0, and all other bits 0.
- R10: ser_dout_oe is 1 only between the 8th and the 32nd rising ser_clk edge of a read frame (0xD1 or 0xD3). It is 0 during the address phase, for write frames, and once the frame has ended.
- R11: The control words change only while ser_frame is low, and never while ser_dout_oe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_dat | input | 1 | Serial data from host |
| ser_frame | input | 1 | Framing line, high during a transfer |
| cnt_result | input | 20 | General counter result |
| gpio_in | input | 5 | Live levels of the general-purpose inputs |
| ser_dout | output | 1 | Serial read data |
| ser_dout_oe | output | 1 | Drive enable for ser_dout (low = high-impedance) |
| ctrl_main | output | 24 | First control word (address 0xD0) |
| ctrl_aux | output | 24 | Second control word (address 0xD2) |
| standby | output | 1 | Standby decode of ctrl_main |

## Verification
The checker covers the properties that hold on every cycle. It checks that the control words move only while the framing line is low and never while the read driver is on, that the test bit never rises, and that the output enable rises only inside an open frame. The bench's scenarios are what show that 31- and 33-edge frames are discarded, that a write to a read-only or unused address does nothing, that read words come out MSB first with the correct contents, and that standby decodes only when all three bits are set.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
    localparam int WORD_W     = 24;
    localparam int ADDR_W     = 8;
    localparam int FRAME_BITS = ADDR_W + WORD_W;

    localparam logic [ADDR_W-1:0] ADDR_MAIN = 8'hD0;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 8'hD1;
    localparam logic [ADDR_W-1:0] ADDR_AUX  = 8'hD2;
    localparam logic [ADDR_W-1:0] ADDR_PORT = 8'hD3;

    typedef struct packed {
        logic [WORD_W-1:0] main;
        logic [WORD_W-1:0] aux;
    } ctrl_regs_t;

    function automatic logic is_read_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_CNT) || (a == ADDR_PORT);
    endfunction

    function automatic logic is_write_addr(input logic [ADDR_W-1:0] a);
        return (a == ADDR_MAIN) || (a == ADDR_AUX);
    endfunction
endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/ssc_frame.sv
module ssc_frame
    import ssc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdat_s,
    input  logic              frm_s,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              dout,
    output logic              dout_oe
);
    localparam int CNT_W   = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  sclk_prev;
        logic                  frm_prev;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sr;
        logic [WORD_W-1:0]     tx;
        logic                  oe;
    } frame_st_t;

    frame_st_t st_d, st_q;
    logic      sclk_rise;
    logic      wr_en_d;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;
    assign rd_addr   = {st_q.sr[ADDR_W-2:0], sdat_s};

    always_comb begin
        st_d           = st_q;
        wr_en_d        = 1'b0;
        st_d.sclk_prev = sclk_s;
        st_d.frm_prev  = frm_s;
        if (frm_s && !st_q.frm_prev) begin
            st_d.cnt = '0;
            st_d.oe  = 1'b0;
        end else if (frm_s && sclk_rise) begin
            st_d.sr = {st_q.sr[FRAME_BITS-2:0], sdat_s};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_ADDR) begin
                st_d.tx = rd_word;
                st_d.oe = is_read_addr(rd_addr);
            end else if (st_q.cnt > CNT_ADDR) begin
                st_d.tx = {st_q.tx[WORD_W-2:0], 1'b0};
                if (st_q.cnt >= CNT_LAST) st_d.oe = 1'b0;
            end
        end else if (!frm_s && st_q.frm_prev) begin
            st_d.oe  = 1'b0;
            st_d.cnt = '0;
            wr_en_d  = (st_q.cnt == CNT_FULL) &&
                       is_write_addr(st_q.sr[FRAME_BITS-1 -: ADDR_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en   = wr_en_d;
    assign wr_addr = st_q.sr[FRAME_BITS-1 -: ADDR_W];
    assign wr_data = st_q.sr[WORD_W-1:0];
    assign dout    = st_q.tx[WORD_W-1];
    assign dout_oe = st_q.oe;
endmodule

// File: rtl/ssc_regs.sv
module ssc_regs
    import ssc_pkg::*;
#(
    parameter logic [WORD_W-1:0] DEF_MAIN = 24'h012345,
    parameter logic [WORD_W-1:0] DEF_AUX  = 24'h000C00,
    parameter int TEST_BIT = 23,
    parameter int STBY_LSB = 21,
    parameter int STBY_W   = 3,
    parameter int CNT_W    = 20,
    parameter int GPIO_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt_result,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] ctrl_main,
    output logic [WORD_W-1:0] ctrl_aux,
    output logic              standby
);
    localparam logic [WORD_W-1:0] TEST_MASK = WORD_W'(1) << TEST_BIT;
    localparam int PORT_PAD = WORD_W - 2 * GPIO_W;

    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_MAIN) regs_d.main = wr_data;
            if (wr_addr == ADDR_AUX)  regs_d.aux  = wr_data & ~TEST_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.main <= DEF_MAIN;
            regs_q.aux  <= DEF_AUX & ~TEST_MASK;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CNT:  rd_word = {{(WORD_W-CNT_W){1'b0}}, cnt_result};
            ADDR_PORT: rd_word = {{PORT_PAD{1'b0}}, regs_q.aux[GPIO_W-1:0], gpio_in};
            default:   rd_word = '0;
        endcase
    end

    assign ctrl_main = regs_q.main;
    assign ctrl_aux  = regs_q.aux;
    assign standby   = &regs_q.main[STBY_LSB +: STBY_W];
endmodule

// File: rtl/ssc_ctrl_if.sv
module ssc_ctrl_if
    import ssc_pkg::*;
#(
    parameter int CNT_W  = 20,
    parameter int GPIO_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_frame,
    input  logic [CNT_W-1:0]  cnt_result,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic              ser_dout,
    output logic              ser_dout_oe,
    output logic [WORD_W-1:0] ctrl_main,
    output logic [WORD_W-1:0] ctrl_aux,
    output logic              standby
);
    logic [2:0]        lines_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [WORD_W-1:0] wr_data;

    ssc_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_frame, ser_dat, ser_clk}),
        .dout  (lines_s)
    );

    ssc_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (lines_s[0]),
        .sdat_s  (lines_s[1]),
        .frm_s   (lines_s[2]),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (ser_dout),
        .dout_oe (ser_dout_oe)
    );

    ssc_regs #(.CNT_W(CNT_W), .GPIO_W(GPIO_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .cnt_result (cnt_result),
        .gpio_in    (gpio_in),
        .rd_word    (rd_word),
        .ctrl_main  (ctrl_main),
        .ctrl_aux   (ctrl_aux),
        .standby    (standby)
    );
endmodule

// File: rtl/ssc_ctrl_chk.sv
module ssc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ser_frame,
    input logic        ser_dout_oe,
    input logic [23:0] ctrl_main,
    input logic [23:0] ctrl_aux
);
    // R11
    main_quiet_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_main) |-> !ser_frame);

    // R11
    aux_quiet_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_aux) |-> !ser_frame);

    // R11
    no_write_while_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_dout_oe |-> ($stable(ctrl_main) && $stable(ctrl_aux)));

    // R10
    oe_rise_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_dout_oe) |-> ser_frame);

    // R6
    test_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_aux[23]);
endmodule

bind ssc_ctrl_if ssc_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_frame   (ser_frame),
    .ser_dout_oe (ser_dout_oe),
    .ctrl_main   (ctrl_main),
    .ctrl_aux    (ctrl_aux)
);

// File: tb/ssc_ctrl_if_tb.sv
module ssc_ctrl_if_tb;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_frame = 1'b0;
    logic [19:0] cnt_result = '0;
    logic [4:0]  gpio_in = '0;
    logic        ser_dout, ser_dout_oe, standby;
    logic [23:0] ctrl_main, ctrl_aux;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssc_ctrl_if u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_frame(ser_frame), .cnt_result(cnt_result), .gpio_in(gpio_in),
        .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe), .ctrl_main(ctrl_main),
        .ctrl_aux(ctrl_aux), .standby(standby)
    );

    typedef struct packed {
        logic [39:0] bits;
        logic [7:0]  n;
        logic [23:0] exp_main;
        logic [23:0] exp_aux;
        logic        exp_stby;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{40'hD0ABCDEF00, 8'd32, 24'hABCDEF, 24'h000C00, 1'b0}, // R3 R1
        '{40'hD2FFFFFF00, 8'd32, 24'hABCDEF, 24'h7FFFFF, 1'b0}, // R6
        '{40'hD0E0000000, 8'd32, 24'hE00000, 24'h7FFFFF, 1'b1}, // R7
        '{40'hD012345600, 8'd31, 24'hE00000, 24'h7FFFFF, 1'b1}, // R2 short
        '{40'hD500000000, 8'd32, 24'hE00000, 24'h7FFFFF, 1'b1}, // R4 unused
        '{40'hD000000000, 8'd33, 24'hE00000, 24'h7FFFFF, 1'b1}, // R2 long
        '{40'hD200001300, 8'd32, 24'hE00000, 24'h000013, 1'b1}, // R3
        '{40'hD1FFFFFF00, 8'd32, 24'hE00000, 24'h000013, 1'b1}, // R4 read addr
        '{40'hD0C0000000, 8'd32, 24'hC00000, 24'h000013, 1'b0}  // R7
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [39:0] bits, input int n, input bit is_rd,
                        output logic [23:0] rd, output int oe_bad);
        rd = '0;
        oe_bad = 0;
        ser_frame = 1'b1;
        wait_clk(HALF);
        for (int i = 0; i < n; i++) begin
            ser_dat = bits[39-i];
            wait_clk(HALF);
            ser_clk = 1'b1;
            wait_clk(HALF);
            if (i >= 7 && i <= 30) rd[30-i] = ser_dout;
            if (ser_dout_oe !== (is_rd && i >= 7 && i <= 30)) oe_bad++;
            ser_clk = 1'b0;
        end
        wait_clk(HALF);
        ser_frame = 1'b0;
        wait_clk(10);
        if (ser_dout_oe !== 1'b0) oe_bad++;
    endtask

    initial begin
        logic [23:0] rd;
        int oe_bad;
        wait_clk(5);
        // R5 reset state
        check(ctrl_main == 24'h012345, "R5", 32'(ctrl_main), 32'h012345);
        check(ctrl_aux == 24'h000C00, "R5", 32'(ctrl_aux), 32'h000C00);
        check(standby == 1'b0 && ser_dout_oe == 1'b0, "R5",
              {30'b0, standby, ser_dout_oe}, 32'h0);
        rst_n = 1'b1;
        wait_clk(5);

        for (int v = 0; v < 9; v++) begin
            send(VECS[v].bits, int'(VECS[v].n), 1'b0, rd, oe_bad);
            check(ctrl_main == VECS[v].exp_main, "R2/R3/R4 main",
                  32'(ctrl_main), 32'(VECS[v].exp_main));
            check(ctrl_aux == VECS[v].exp_aux, "R3/R4/R6 aux",
                  32'(ctrl_aux), 32'(VECS[v].exp_aux));
            check(standby == VECS[v].exp_stby, "R7 standby",
                  32'(standby), 32'(VECS[v].exp_stby));
            if (VECS[v].bits[39:32] != 8'hD1)
                check(oe_bad == 0, "R10 oe on write", oe_bad, 0);
        end

        // R8 counter read, MSB first
        cnt_result = 20'hA5C3F;
        send(40'hD100000000, 32, 1'b1, rd, oe_bad);
        check(rd == 24'h0A5C3F, "R8 cnt read", 32'(rd), 32'h0A5C3F);
        check(oe_bad == 0, "R10 oe on read", oe_bad, 0);
        check(ctrl_main == 24'hC00000, "R4 read no write", 32'(ctrl_main), 32'hC00000);

        // R9 port readback: aux[4:0]=10011, gpio=10110
        gpio_in = 5'h16;
        send(40'hD300000000, 32, 1'b1, rd, oe_bad);
        check(rd == 24'h000276, "R9 port read", 32'(rd), 32'h000276);
        check(oe_bad == 0, "R10 oe on port read", oe_bad, 0);

        // R10 truncated read frame releases the line
        send(40'hD100000000, 16, 1'b1, rd, oe_bad);
        check(oe_bad == 0, "R10 truncated read", oe_bad, 0);
        check(ctrl_aux == 24'h000013, "R4 truncated read", 32'(ctrl_aux), 32'h000013);

        // R1 bit order: asymmetric pattern
        send(40'hD080000100, 32, 1'b0, rd, oe_bad);
        check(ctrl_main == 24'h800001, "R1 msb first", 32'(ctrl_main), 32'h800001);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule